// File: doc/BRIEF.md
# Write-Once Clearable Byte Memory Emulator

This block is a synthesizable stand-in for a byte-wide memory that can be programmed a bit at a time and then cleared as a whole. It is the target device when a programmer controller is brought up, so that controller can be tested without a real part. The controller places an address and a byte on the pins, raises the program-voltage-present flag, selects the part and pulses the program strobe low. Each pulse can only clear bits of the addressed byte. Bits return to 1 only when the bulk erase input is asserted, which plays the role of exposing the part to light.

The bus is bidirectional at the pad. Inside the chip it is split into an input byte, an output byte and an output-enable flag. The pad cell builds the tri-state driver from these. Read data is combinational from the address and controls. A margin input makes reads stricter: a cleared bit reports as 0 only after its byte has received enough program pulses. This lets a controller run a pulse-and-verify loop. The memory depth is a power-of-two parameter, and address bits above the index width are ignored, so addresses wrap around.

Top module: `otpemu_top`

## Requirements
- R1: After reset, and after any clock edge at which `eraseReq` is high, every byte reads 0xFF in both normal and margin reads, and every pulse counter is zero.
- R2: A program pulse updates the addressed byte as stored = stored AND `dataIn`. A 1 in `dataIn` leaves its bit unchanged, and no bit ever goes from 0 to 1 except through R1.
- R3: A program pulse is taken at a clock edge where `progN` is sampled low and was sampled high at the previous edge, `vppOk` is high and `ceN` is low. Holding `progN` low over further edges adds no pulse, and with `vppOk` low nothing changes.
- R4: `dataOe` is 1 exactly when `ceN` and `oeN` are both 0. While `dataOe` is 0, `dataOut` is 0x00.
- R5: While `ceN` is high the part is in standby. Program pulses are ignored and the output is not enabled.
- R6: With `marginMode` low, a read returns the stored byte. With `marginMode` high, a bit reads 0 only if it is stored as 0 and its byte has received at least MARGIN_PULSES pulses (default 2) since the last erase. Otherwise it reads 1. The count saturates at MARGIN_PULSES.
- R7: The array index is `addr` modulo DEPTH (default DEPTH 16, `addr` 6 bits), so addresses a, a+16, a+32 name the same byte.
- R8: Read data follows `addr`, `marginMode`, `ceN` and `oeN` within the same cycle, with no clock edge in between.
- R9: When erase and a valid program pulse fall on the same edge, the erase wins. The array reads all 0xFF and every pulse count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and erase |
| rstN | input | 1 | Asynchronous active-low reset, leaves the array erased |
| addr | input | ADDR_W | Byte address, wraps modulo DEPTH |
| dataIn | input | 8 | Pad-side input byte, used as program data |
| dataOut | output | 8 | Pad-side read byte |
| dataOe | output | 1 | Pad output enable for the data bus |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| progN | input | 1 | Program strobe, active low pulse |
| vppOk | input | 1 | Program voltage present |
| marginMode | input | 1 | Selects margin (verify) reads |
| eraseReq | input | 1 | Bulk erase, sampled at the clock |

## Verification
Reads are combinational, so the bench checks them 1 ns after it changes the address or controls, with no clock edge in between. A program pulse or an erase is driven at a falling edge and takes effect at the next rising edge, which is the one that samples it. Every read that follows is made at a later falling edge. The bench keeps its own copy of the bytes and pulse counts and updates it at the same point where the design registers the pulse. Across full address sweeps, it compares each byte against that copy for normal reads and for margin reads.

// File: rtl/otpemu_pkg.sv
package otpemu_pkg;
  typedef struct packed {
    logic wrStb;
    logic clrAll;
  } ctlStrobes_t;
endpackage

// File: rtl/otpemu_ctrl.sv
module otpemu_ctrl
  import otpemu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        progN,
  input  logic        vppOk,
  input  logic        eraseReq,
  output ctlStrobes_t stb
);
  logic progPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progPrev <= 1'b1;
    else       progPrev <= progN;
  end

  always_comb begin
    stb.wrStb  = !ceN && vppOk && progPrev && !progN;
    stb.clrAll = eraseReq;
  end
endmodule

// File: rtl/otpemu_array.sv
module otpemu_array
  import otpemu_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int MARGIN_PULSES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              stb,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [7:0]               dataIn,
  input  logic                     ceN,
  input  logic                     oeN,
  input  logic                     marginMode,
  output logic [7:0]               rdRaw,
  output logic [7:0]               dataOut,
  output logic                     dataOe
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(MARGIN_PULSES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MARGIN_PULSES);

  logic [DEPTH-1:0][7:0]       byteVec;
  logic [DEPTH-1:0][CNT_W-1:0] cntVec;

  for (genvar i = 0; i < DEPTH; i++) begin : gCell
    logic [7:0]       cellByte;
    logic [CNT_W-1:0] cellCnt;
    logic             hit;

    assign hit = stb.wrStb && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellByte <= 8'hFF;
        cellCnt  <= '0;
      end else if (stb.clrAll) begin
        cellByte <= 8'hFF;
        cellCnt  <= '0;
      end else if (hit) begin
        cellByte <= cellByte & dataIn;
        if (cellCnt != CNT_MAX) cellCnt <= cellCnt + 1'b1;
      end
    end

    assign byteVec[i] = cellByte;
    assign cntVec[i]  = cellCnt;
  end

  logic [7:0] rdMargin;

  always_comb begin
    rdRaw    = byteVec[idx];
    rdMargin = (cntVec[idx] >= CNT_MAX) ? rdRaw : 8'hFF;
    dataOe   = !ceN && !oeN;
    if (dataOe) dataOut = marginMode ? rdMargin : rdRaw;
    else        dataOut = 8'h00;
  end
endmodule

// File: rtl/otpemu_top.sv
module otpemu_top
  import otpemu_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int ADDR_W        = 6,
  parameter int MARGIN_PULSES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              progN,
  input  logic              vppOk,
  input  logic              marginMode,
  input  logic              eraseReq
);
  localparam int IDX_W = $clog2(DEPTH);

  ctlStrobes_t      stb;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rdRaw;

  assign idx = addr[IDX_W-1:0];

  otpemu_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .progN    (progN),
    .vppOk    (vppOk),
    .eraseReq (eraseReq),
    .stb      (stb)
  );

  otpemu_array #(
    .DEPTH         (DEPTH),
    .MARGIN_PULSES (MARGIN_PULSES)
  ) uArray (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .idx        (idx),
    .dataIn     (dataIn),
    .ceN        (ceN),
    .oeN        (oeN),
    .marginMode (marginMode),
    .rdRaw      (rdRaw),
    .dataOut    (dataOut),
    .dataOe     (dataOe)
  );
endmodule

// File: rtl/otpemu_chk.sv
module otpemu_chk
  import otpemu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic              progN,
  input logic              vppOk,
  input logic              marginMode,
  input logic              eraseReq,
  input ctlStrobes_t       stb,
  input logic [7:0]        rdRaw,
  input logic [7:0]        dataOut,
  input logic              dataOe
);
  a_r1_erase_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> (rdRaw == 8'hFF));

  a_r2_no_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(addr) && !$past(eraseReq)) |-> ((rdRaw & ~$past(rdRaw)) == 8'h00));

  a_r3_pulse_edge: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |-> (!progN && $past(progN) && vppOk));

  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

  a_r5_standby: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (!stb.wrStb && !dataOe));

  a_r6_margin_strict: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && marginMode) |-> ((~dataOut & rdRaw) == 8'h00));
endmodule

bind otpemu_top otpemu_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .ceN        (ceN),
  .progN      (progN),
  .vppOk      (vppOk),
  .marginMode (marginMode),
  .eraseReq   (eraseReq),
  .stb        (stb),
  .rdRaw      (rdRaw),
  .dataOut    (dataOut),
  .dataOe     (dataOe)
);

// File: tb/otpemu_top_test.sv
`timescale 1ns/1ps
module otpemu_top_test;
  localparam int DEPTH = 16;
  localparam int ADDR_W = 6;
  localparam int NEED = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = 8'hFF;
  logic [7:0] dataOut;
  logic dataOe;
  logic ceN = 1'b1, oeN = 1'b1, progN = 1'b1, vppOk = 1'b0;
  logic marginMode = 1'b0, eraseReq = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [7:0] expMem [DEPTH];
  int expCnt [DEPTH];

  always #10 clk = ~clk;

  otpemu_top uut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .ceN(ceN), .oeN(oeN), .progN(progN), .vppOk(vppOk),
    .marginMode(marginMode), .eraseReq(eraseReq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] marginExp(int i);
    return (expCnt[i] >= NEED) ? expMem[i] : 8'hFF;
  endfunction

  task automatic modelErase();
    for (int i = 0; i < DEPTH; i++) begin
      expMem[i] = 8'hFF;
      expCnt[i] = 0;
    end
  endtask

  task automatic modelProg(int a, logic [7:0] d);
    int i = a % DEPTH;
    expMem[i] = expMem[i] & d;
    if (expCnt[i] < NEED) expCnt[i]++;
  endtask

  task automatic readChk(string req, int a, logic mm, logic [7:0] exp);
    @(negedge clk);
    addr = ADDR_W'(a);
    marginMode = mm;
    ceN = 1'b0;
    oeN = 1'b0;
    #1;
    chk(req, dataOut, exp);
  endtask

  task automatic pulse(int a, logic [7:0] d, logic vpp, logic ce, int hold);
    @(negedge clk);
    addr = ADDR_W'(a);
    dataIn = d;
    vppOk = vpp;
    ceN = ce;
    oeN = 1'b1;
    progN = 1'b0;
    repeat (hold) @(negedge clk);
    progN = 1'b1;
    vppOk = 1'b0;
    @(negedge clk);
  endtask

  task automatic eraseAll();
    @(negedge clk);
    eraseReq = 1'b1;
    @(negedge clk);
    eraseReq = 1'b0;
    modelErase();
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < DEPTH; a++) begin
      readChk(req, a, 1'b0, expMem[a]);
      readChk(req, a, 1'b1, marginExp(a));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    modelErase();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, normal and margin
    sweep("R1 reset");

    // R4 / R5: output enable gating
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; #1;
    chk("R4 oe on", {7'b0, dataOe}, 8'h01);
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; #1;
    chk("R4 oe off", {7'b0, dataOe}, 8'h00);
    chk("R4 quiet data", dataOut, 8'h00);
    @(negedge clk); ceN = 1'b1; oeN = 1'b0; #1;
    chk("R5 standby oe", {7'b0, dataOe}, 8'h00);

    // R2 / R6: first pass, one pulse per byte
    for (int a = 0; a < DEPTH; a++) begin
      pulse(a, 8'((a * 37) + 5), 1'b1, 1'b0, 1);
      modelProg(a, 8'((a * 37) + 5));
    end
    sweep("R6 one pulse");
    // R2: second pass ANDs a second pattern
    for (int a = 0; a < DEPTH; a++) begin
      pulse(a, 8'((a * 11) + 60), 1'b1, 1'b0, 1);
      modelProg(a, 8'((a * 11) + 60));
    end
    sweep("R2 and pass");
    // R2: all-ones data leaves byte unchanged
    pulse(4, 8'hFF, 1'b1, 1'b0, 1);
    modelProg(4, 8'hFF);
    readChk("R2 ones keep", 4, 1'b0, expMem[4]);

    // R3: no program voltage, R5: deselected
    pulse(9, 8'h00, 1'b0, 1'b0, 1);
    readChk("R3 no vpp", 9, 1'b0, expMem[9]);
    pulse(10, 8'h00, 1'b1, 1'b1, 1);
    readChk("R5 standby prog", 10, 1'b0, expMem[10]);

    // R1: erase clears data and counts
    eraseAll();
    sweep("R1 erase");

    // R3: held strobe counts as one pulse
    pulse(5, 8'h0F, 1'b1, 1'b0, 3);
    modelProg(5, 8'h0F);
    readChk("R3 held normal", 5, 1'b0, 8'h0F);
    readChk("R3 held margin", 5, 1'b1, 8'hFF);
    pulse(5, 8'hFF, 1'b1, 1'b0, 1);
    modelProg(5, 8'hFF);
    readChk("R6 second pulse", 5, 1'b1, 8'h0F);
    // R6: saturation, extra pulses keep margin view
    pulse(5, 8'h3F, 1'b1, 1'b0, 1);
    modelProg(5, 8'h3F);
    readChk("R6 saturate", 5, 1'b1, 8'h0F);

    // R7: address wrap
    pulse(16 + 3, 8'hF0, 1'b1, 1'b0, 1);
    modelProg(3, 8'hF0);
    readChk("R7 wrap low", 3, 1'b0, 8'hF0);
    readChk("R7 wrap high", 32 + 3, 1'b0, 8'hF0);
    readChk("R7 wrap neighbour", 48 + 2, 1'b0, 8'hFF);

    // R8: read follows address without clock edge
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; marginMode = 1'b0;
    addr = 6'd3; #1;
    chk("R8 comb a", dataOut, 8'hF0);
    addr = 6'd5; #1;
    chk("R8 comb b", dataOut, 8'h0F);
    marginMode = 1'b1; addr = 6'd3; #1;
    chk("R8 comb margin", dataOut, 8'hFF);

    // R9: erase wins over a same-edge program
    @(negedge clk);
    oeN = 1'b1; ceN = 1'b0; vppOk = 1'b1;
    addr = 6'd7; dataIn = 8'h00; progN = 1'b0; eraseReq = 1'b1;
    @(negedge clk);
    eraseReq = 1'b0; progN = 1'b1; vppOk = 1'b0;
    modelErase();
    readChk("R9 erase wins", 7, 1'b0, 8'hFF);
    readChk("R9 others", 5, 1'b0, 8'hFF);
    pulse(7, 8'h55, 1'b1, 1'b0, 1);
    modelProg(7, 8'h55);
    readChk("R9 count cleared", 7, 1'b1, 8'hFF);
    readChk("R9 data", 7, 1'b0, 8'h55);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule